// File: doc/BRIEF.md
# Register Window and Trap Sequencer

This block keeps the current window pointer of a windowed register file and runs the control side of trap entry and trap return for a small processor core. The decode stage gives it one-cycle strobes for window save, window restore, software trap, trap return and status write. It also receives an external interrupt request with a 6-bit priority, plus the operands these operations need: the current PC, the frame pointer, a save immediate and a return register value. The block drives the window pointer, the status word and its saved copy, and single-cycle write requests for the stack pointer and the link register. It also fetches a trap vector and then presents the new PC.

Running out of windows is not an error. A save at the lowest allowed window becomes trap 1, and a restore at the highest allowed window becomes trap 2. Every trap, whether from software, from a window limit or from an interrupt, follows one entry sequence. That sequence saves the status word, masks interrupts, moves down one window, records the trap number as the new priority, writes the return index to the link register and fetches the handler address. The vector fetch uses a valid/ready request channel followed by a valid/ready response channel. While the fetch is outstanding the block reports busy and accepts nothing.

Top module: `regwin_trap_ctrl`

## Requirements
- R1: A save strobe with the window pointer above the low limit lowers the window pointer by one after the accepting edge. In the following cycle, sp_we_o pulses once with sp_data_o = fp_i - 4*save_imm_i.
- R2: A save strobe with the window pointer equal to the low limit does not write the stack pointer. It starts trap entry with trap number 1 instead.
- R3: A restore strobe below the high limit raises the window pointer by one. A restore strobe at the high limit starts trap entry with trap number 2.
- R4: Trap entry copies the status word into the saved status word, clears the interrupt enable, lowers the window pointer by one and loads the priority field with the trap number. All of these are visible after the accepting edge.
- R5: Trap entry pulses link_we_o for one cycle after the accepting edge, with link_data_o = (pc_i + 2) >> 1.
- R6: Trap entry raises vec_req_valid_o with vec_addr_o = VEC_BASE + 4*trap number. Both are held unchanged until vec_req_ready_i is seen. vec_rsp_ready_o is then high until vec_rsp_valid_i arrives. The edge of that response handshake makes pc_valid_o pulse for one cycle with pc_o = vec_rsp_data_i << 1.
- R7: A trap-return strobe restores the window pointer, interrupt enable and priority from the saved status word. In the next cycle it pulses pc_valid_o with pc_o = tret_reg_i << 1.
- R8: After reset the window pointer equals HI_LIM, the interrupt enable is 0, the priority field is 63, the saved status word is 0 and all pulse outputs are low.
- R9: busy_o is high from the trap-entry edge until the response handshake. While it is high, no strobe and no interrupt changes the window pointer, the status word or the write pulses.
- R10: The status word has the window pointer in bits [3:0], the low limit in [7:4], the high limit in [11:8], the interrupt enable in bit 12 and the priority in [18:13]; all other bits are 0. A status-write strobe loads the window pointer, enable and priority from status_wdata_i, and the two limits are read-only.
- R11: An interrupt request is taken only when the enable is 1 and irq_pri_i is numerically below the current priority field. The request's priority is used as the trap number.
- R12: When several requests arrive in one idle cycle, only one is served, in this order: interrupt, software trap, trap return, save, restore, status write. The others are dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| save_i | input | 1 | Window save strobe |
| restore_i | input | 1 | Window restore strobe |
| trap_i | input | 1 | Software trap strobe |
| trap_num_i | input | 6 | Software trap number |
| tret_i | input | 1 | Trap return strobe |
| tret_reg_i | input | 32 | Return register value (half-word index) |
| status_we_i | input | 1 | Status write strobe |
| status_wdata_i | input | 32 | Status write data |
| irq_i | input | 1 | External interrupt request |
| irq_pri_i | input | 6 | Interrupt priority |
| pc_i | input | 32 | PC of the current instruction |
| fp_i | input | 32 | Frame pointer value |
| save_imm_i | input | 8 | Save frame size in words |
| vec_req_valid_o | output | 1 | Vector read request valid |
| vec_req_ready_i | input | 1 | Vector read request ready |
| vec_addr_o | output | 32 | Vector read address |
| vec_rsp_valid_i | input | 1 | Vector word valid |
| vec_rsp_ready_o | output | 1 | Vector word ready |
| vec_rsp_data_i | input | 32 | Vector word |
| busy_o | output | 1 | Vector fetch in progress |
| cwp_o | output | 4 | Current window pointer |
| ie_o | output | 1 | Interrupt enable |
| status_o | output | 32 | Status word |
| istatus_o | output | 32 | Saved status word |
| sp_we_o | output | 1 | Stack pointer write pulse |
| sp_data_o | output | 32 | New stack pointer |
| link_we_o | output | 1 | Link register write pulse |
| link_data_o | output | 32 | Return half-word index |
| pc_valid_o | output | 1 | New PC pulse |
| pc_o | output | 32 | New PC |

## Verification
The interesting collision is an enabled interrupt arriving in the same cycle as a save strobe. The bench drives both on one falling edge. After the rising edge it checks that the window pointer moved down exactly once, that no stack-pointer write happened, and that the priority field and the vector address carry the interrupt's priority rather than anything belonging to the save. Two further collisions are provoked in the same way: a software trap together with a restore, and a save strobe issued while a vector request is held off by a low ready. In both cases only the winning operation may be seen at the ports.

// File: rtl/regwin_pkg.sv
package regwin_pkg;
  localparam int PRI_W = 6;

  typedef enum logic [2:0] {
    EV_NONE,
    EV_ENTRY,
    EV_TRET,
    EV_SAVE,
    EV_RESTORE,
    EV_WRITE
  } ev_e;

  typedef enum logic [1:0] {
    FS_IDLE,
    FS_REQ,
    FS_WAIT
  } fetch_st_e;

  localparam logic [PRI_W-1:0] TRAPNO_WIN_OVF = 6'd1;
  localparam logic [PRI_W-1:0] TRAPNO_WIN_UNF = 6'd2;
  localparam logic [PRI_W-1:0] PRI_RESET      = 6'd63;
endpackage

// File: rtl/regwin_window.sv
module regwin_window #(
  parameter int CWP_W  = 4,
  parameter int LO_LIM = 1,
  parameter int HI_LIM = 6,
  parameter int DATA_W = 32,
  parameter int IMM_W  = 8
) (
  input  logic [CWP_W-1:0]  cwp,
  input  logic [DATA_W-1:0] fp,
  input  logic [IMM_W-1:0]  imm,
  output logic              at_lo,
  output logic              at_hi,
  output logic [CWP_W-1:0]  cwp_down,
  output logic [CWP_W-1:0]  cwp_up,
  output logic [DATA_W-1:0] sp_next
);
  localparam logic [CWP_W-1:0] LO_V = CWP_W'(LO_LIM);
  localparam logic [CWP_W-1:0] HI_V = CWP_W'(HI_LIM);

  logic [DATA_W-1:0] frame_bytes;

  always_comb begin
    at_lo       = (cwp == LO_V);
    at_hi       = (cwp == HI_V);
    cwp_down    = cwp - CWP_W'(1);
    cwp_up      = cwp + CWP_W'(1);
    frame_bytes = DATA_W'(imm) << 2;
    sp_next     = fp - frame_bytes;
  end
endmodule

// File: rtl/regwin_arbiter.sv
module regwin_arbiter
  import regwin_pkg::*;
(
  input  logic             idle,
  input  logic             irq,
  input  logic [PRI_W-1:0] irq_pri,
  input  logic             ie,
  input  logic [PRI_W-1:0] cur_pri,
  input  logic             trap,
  input  logic [PRI_W-1:0] trap_num,
  input  logic             tret,
  input  logic             save,
  input  logic             restore,
  input  logic             st_we,
  input  logic             at_lo,
  input  logic             at_hi,
  output ev_e              ev,
  output logic [PRI_W-1:0] ev_num
);
  logic irq_take;

  always_comb begin
    irq_take = irq && ie && (irq_pri < cur_pri);
    ev       = EV_NONE;
    ev_num   = '0;
    if (idle) begin
      if (irq_take) begin
        ev     = EV_ENTRY;
        ev_num = irq_pri;
      end else if (trap) begin
        ev     = EV_ENTRY;
        ev_num = trap_num;
      end else if (tret) begin
        ev = EV_TRET;
      end else if (save) begin
        if (at_lo) begin
          ev     = EV_ENTRY;
          ev_num = TRAPNO_WIN_OVF;
        end else begin
          ev = EV_SAVE;
        end
      end else if (restore) begin
        if (at_hi) begin
          ev     = EV_ENTRY;
          ev_num = TRAPNO_WIN_UNF;
        end else begin
          ev = EV_RESTORE;
        end
      end else if (st_we) begin
        ev = EV_WRITE;
      end
    end
  end
endmodule

// File: rtl/regwin_vec_fetch.sv
module regwin_vec_fetch
  import regwin_pkg::*;
#(
  parameter int              DATA_W   = 32,
  parameter logic [31:0]     VEC_BASE = 32'h0000_0400
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [PRI_W-1:0]  num,
  output logic              req_valid,
  input  logic              req_ready,
  output logic [DATA_W-1:0] addr,
  input  logic              rsp_valid,
  output logic              rsp_ready,
  input  logic [DATA_W-1:0] rsp_data,
  output logic              busy,
  output logic              done,
  output logic [DATA_W-1:0] target
);
  fetch_st_e         st_q;
  logic [DATA_W-1:0] addr_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= FS_IDLE;
      addr_q <= '0;
    end else begin
      unique case (st_q)
        FS_IDLE: if (start) begin
          st_q   <= FS_REQ;
          addr_q <= DATA_W'(VEC_BASE) + (DATA_W'(num) << 2);
        end
        FS_REQ:  if (req_ready) st_q <= FS_WAIT;
        FS_WAIT: if (rsp_valid) st_q <= FS_IDLE;
        default: st_q <= FS_IDLE;
      endcase
    end
  end

  always_comb begin
    req_valid = (st_q == FS_REQ);
    rsp_ready = (st_q == FS_WAIT);
    busy      = (st_q != FS_IDLE);
    done      = rsp_ready && rsp_valid;
    addr      = addr_q;
    target    = rsp_data << 1;
  end
endmodule

// File: rtl/regwin_trap_ctrl.sv
module regwin_trap_ctrl
  import regwin_pkg::*;
#(
  parameter int          CWP_W    = 4,
  parameter int          LO_LIM   = 1,
  parameter int          HI_LIM   = 6,
  parameter int          DATA_W   = 32,
  parameter int          IMM_W    = 8,
  parameter logic [31:0] VEC_BASE = 32'h0000_0400
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              save_i,
  input  logic              restore_i,
  input  logic              trap_i,
  input  logic [5:0]        trap_num_i,
  input  logic              tret_i,
  input  logic [DATA_W-1:0] tret_reg_i,
  input  logic              status_we_i,
  input  logic [DATA_W-1:0] status_wdata_i,
  input  logic              irq_i,
  input  logic [5:0]        irq_pri_i,
  input  logic [DATA_W-1:0] pc_i,
  input  logic [DATA_W-1:0] fp_i,
  input  logic [IMM_W-1:0]  save_imm_i,
  output logic              vec_req_valid_o,
  input  logic              vec_req_ready_i,
  output logic [DATA_W-1:0] vec_addr_o,
  input  logic              vec_rsp_valid_i,
  output logic              vec_rsp_ready_o,
  input  logic [DATA_W-1:0] vec_rsp_data_i,
  output logic              busy_o,
  output logic [CWP_W-1:0]  cwp_o,
  output logic              ie_o,
  output logic [DATA_W-1:0] status_o,
  output logic [DATA_W-1:0] istatus_o,
  output logic              sp_we_o,
  output logic [DATA_W-1:0] sp_data_o,
  output logic              link_we_o,
  output logic [DATA_W-1:0] link_data_o,
  output logic              pc_valid_o,
  output logic [DATA_W-1:0] pc_o
);
  localparam int LO_POS  = CWP_W;
  localparam int HI_POS  = 2 * CWP_W;
  localparam int IE_POS  = 3 * CWP_W;
  localparam int PRI_POS = IE_POS + 1;
  localparam logic [CWP_W-1:0] LO_V = CWP_W'(LO_LIM);
  localparam logic [CWP_W-1:0] HI_V = CWP_W'(HI_LIM);

  logic [CWP_W-1:0]  cwp_q;
  logic              ie_q;
  logic [PRI_W-1:0]  pri_q;
  logic [DATA_W-1:0] istatus_q;
  logic              sp_we_q, link_we_q, pc_valid_q;
  logic [DATA_W-1:0] sp_q, link_q, pc_q;
  logic [DATA_W-1:0] status_w;

  logic              at_lo, at_hi;
  logic [CWP_W-1:0]  cwp_down, cwp_up;
  logic [DATA_W-1:0] sp_next;
  ev_e               ev;
  logic [PRI_W-1:0]  ev_num;
  logic              f_busy, f_done;
  logic [DATA_W-1:0] f_target;

  regwin_window #(
    .CWP_W(CWP_W), .LO_LIM(LO_LIM), .HI_LIM(HI_LIM),
    .DATA_W(DATA_W), .IMM_W(IMM_W)
  ) u_window (
    .cwp(cwp_q), .fp(fp_i), .imm(save_imm_i),
    .at_lo(at_lo), .at_hi(at_hi),
    .cwp_down(cwp_down), .cwp_up(cwp_up), .sp_next(sp_next)
  );

  regwin_arbiter u_arb (
    .idle(!f_busy), .irq(irq_i), .irq_pri(irq_pri_i), .ie(ie_q),
    .cur_pri(pri_q), .trap(trap_i), .trap_num(trap_num_i),
    .tret(tret_i), .save(save_i), .restore(restore_i),
    .st_we(status_we_i), .at_lo(at_lo), .at_hi(at_hi),
    .ev(ev), .ev_num(ev_num)
  );

  regwin_vec_fetch #(.DATA_W(DATA_W), .VEC_BASE(VEC_BASE)) u_fetch (
    .clk(clk), .rst_n(rst_n),
    .start(ev == EV_ENTRY), .num(ev_num),
    .req_valid(vec_req_valid_o), .req_ready(vec_req_ready_i),
    .addr(vec_addr_o),
    .rsp_valid(vec_rsp_valid_i), .rsp_ready(vec_rsp_ready_o),
    .rsp_data(vec_rsp_data_i),
    .busy(f_busy), .done(f_done), .target(f_target)
  );

  always_comb begin
    status_w = '0;
    status_w[LO_POS-1:0]         = cwp_q;
    status_w[HI_POS-1:LO_POS]    = LO_V;
    status_w[IE_POS-1:HI_POS]    = HI_V;
    status_w[IE_POS]             = ie_q;
    status_w[PRI_POS +: PRI_W]   = pri_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cwp_q      <= HI_V;
      ie_q       <= 1'b0;
      pri_q      <= PRI_RESET;
      istatus_q  <= '0;
      sp_we_q    <= 1'b0;
      sp_q       <= '0;
      link_we_q  <= 1'b0;
      link_q     <= '0;
      pc_valid_q <= 1'b0;
      pc_q       <= '0;
    end else begin
      sp_we_q    <= 1'b0;
      link_we_q  <= 1'b0;
      pc_valid_q <= 1'b0;
      unique case (ev)
        EV_ENTRY: begin
          istatus_q <= status_w;
          ie_q      <= 1'b0;
          cwp_q     <= cwp_down;
          pri_q     <= ev_num;
          link_we_q <= 1'b1;
          link_q    <= (pc_i + DATA_W'(2)) >> 1;
        end
        EV_TRET: begin
          cwp_q      <= istatus_q[LO_POS-1:0];
          ie_q       <= istatus_q[IE_POS];
          pri_q      <= istatus_q[PRI_POS +: PRI_W];
          pc_valid_q <= 1'b1;
          pc_q       <= tret_reg_i << 1;
        end
        EV_SAVE: begin
          cwp_q   <= cwp_down;
          sp_we_q <= 1'b1;
          sp_q    <= sp_next;
        end
        EV_RESTORE: cwp_q <= cwp_up;
        EV_WRITE: begin
          cwp_q <= status_wdata_i[LO_POS-1:0];
          ie_q  <= status_wdata_i[IE_POS];
          pri_q <= status_wdata_i[PRI_POS +: PRI_W];
        end
        default: ;
      endcase
      if (f_done) begin
        pc_valid_q <= 1'b1;
        pc_q       <= f_target;
      end
    end
  end

  always_comb begin
    busy_o      = f_busy;
    cwp_o       = cwp_q;
    ie_o        = ie_q;
    status_o    = status_w;
    istatus_o   = istatus_q;
    sp_we_o     = sp_we_q;
    sp_data_o   = sp_q;
    link_we_o   = link_we_q;
    link_data_o = link_q;
    pc_valid_o  = pc_valid_q;
    pc_o        = pc_q;
  end
endmodule

// File: rtl/regwin_trap_ctrl_chk.sv
module regwin_trap_ctrl_chk #(
  parameter int CWP_W  = 4,
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              save_i,
  input logic              restore_i,
  input logic              trap_i,
  input logic              tret_i,
  input logic              busy_o,
  input logic [CWP_W-1:0]  cwp_o,
  input logic              ie_o,
  input logic              sp_we_o,
  input logic              link_we_o,
  input logic              vec_req_valid_o,
  input logic              vec_req_ready_i,
  input logic [DATA_W-1:0] vec_addr_o,
  input logic              vec_rsp_ready_o
);
  AST_BUSY_FREEZES_CWP: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && (save_i || restore_i || trap_i || tret_i)) |=> $stable(cwp_o)); // R9
  AST_ENTRY_MASKS_IE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy_o) |-> !ie_o); // R4
  AST_LINK_IN_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
    link_we_o |-> busy_o); // R5
  AST_REQ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (vec_req_valid_o && !vec_req_ready_i) |=> (vec_req_valid_o && $stable(vec_addr_o))); // R6
  AST_ONE_CHANNEL: assert property (@(posedge clk) disable iff (!rst_n)
    !(vec_req_valid_o && vec_rsp_ready_o)); // R6
  AST_SAVE_STEPS_DOWN: assert property (@(posedge clk) disable iff (!rst_n)
    sp_we_o |-> (cwp_o == $past(cwp_o) - CWP_W'(1))); // R1
endmodule

bind regwin_trap_ctrl regwin_trap_ctrl_chk #(.CWP_W(CWP_W), .DATA_W(DATA_W)) i_chk (
  .clk(clk), .rst_n(rst_n), .save_i(save_i), .restore_i(restore_i),
  .trap_i(trap_i), .tret_i(tret_i), .busy_o(busy_o), .cwp_o(cwp_o),
  .ie_o(ie_o), .sp_we_o(sp_we_o), .link_we_o(link_we_o),
  .vec_req_valid_o(vec_req_valid_o), .vec_req_ready_i(vec_req_ready_i),
  .vec_addr_o(vec_addr_o), .vec_rsp_ready_o(vec_rsp_ready_o)
);

// File: tb/test_regwin_trap_ctrl.sv
module test_regwin_trap_ctrl;
  localparam int          CLK_PERIOD = 10;
  localparam int          LO = 1;
  localparam int          HI = 6;
  localparam logic [31:0] VB = 32'h0000_0400;
  localparam int          WATCHDOG = 20000;

  logic clk = 0;
  logic rst_n = 0;
  logic save_i = 0, restore_i = 0, trap_i = 0, tret_i = 0, status_we_i = 0, irq_i = 0;
  logic [5:0]  trap_num_i = 0, irq_pri_i = 0;
  logic [31:0] tret_reg_i = 0, status_wdata_i = 0, pc_i = 0, fp_i = 0;
  logic [7:0]  save_imm_i = 0;
  logic vec_req_ready_i = 0, vec_rsp_valid_i = 0;
  logic [31:0] vec_rsp_data_i = 0;
  logic vec_req_valid_o, vec_rsp_ready_o, busy_o, ie_o, sp_we_o, link_we_o, pc_valid_o;
  logic [31:0] vec_addr_o, status_o, istatus_o, sp_data_o, link_data_o, pc_o;
  logic [3:0]  cwp_o;

  int n_chk = 0;
  int n_fail = 0;
  int cycles = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  regwin_trap_ctrl i_regwin_trap_ctrl (
    .clk(clk), .rst_n(rst_n), .save_i(save_i), .restore_i(restore_i),
    .trap_i(trap_i), .trap_num_i(trap_num_i), .tret_i(tret_i),
    .tret_reg_i(tret_reg_i), .status_we_i(status_we_i),
    .status_wdata_i(status_wdata_i), .irq_i(irq_i), .irq_pri_i(irq_pri_i),
    .pc_i(pc_i), .fp_i(fp_i), .save_imm_i(save_imm_i),
    .vec_req_valid_o(vec_req_valid_o), .vec_req_ready_i(vec_req_ready_i),
    .vec_addr_o(vec_addr_o), .vec_rsp_valid_i(vec_rsp_valid_i),
    .vec_rsp_ready_o(vec_rsp_ready_o), .vec_rsp_data_i(vec_rsp_data_i),
    .busy_o(busy_o), .cwp_o(cwp_o), .ie_o(ie_o), .status_o(status_o),
    .istatus_o(istatus_o), .sp_we_o(sp_we_o), .sp_data_o(sp_data_o),
    .link_we_o(link_we_o), .link_data_o(link_data_o),
    .pc_valid_o(pc_valid_o), .pc_o(pc_o)
  );

  function automatic logic [31:0] mk(int c, int ie, int p);
    return 32'(c) | (32'(LO) << 4) | (32'(HI) << 8) | (32'(ie) << 12) | (32'(p) << 13);
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > WATCHDOG) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual %0d expected below %0d", cycles, WATCHDOG);
      finish_run();
    end
  end

  task automatic tick();
    @(negedge clk);
  endtask

  // Serves a pending vector fetch; called at a falling edge right after entry.
  task automatic serve(string req, logic [31:0] exp_addr, logic [31:0] word, int hold);
    check({req, " req valid"}, 32'(vec_req_valid_o), 1);
    check({req, " vec addr"}, vec_addr_o, exp_addr);
    for (int i = 0; i < hold; i++) begin
      tick();
      check("R6 req held", 32'(vec_req_valid_o), 1);
      check("R6 addr held", vec_addr_o, exp_addr);
    end
    vec_req_ready_i = 1;
    tick();
    vec_req_ready_i = 0;
    check("R6 rsp ready", 32'(vec_rsp_ready_o), 1);
    check("R6 req dropped", 32'(vec_req_valid_o), 0);
    vec_rsp_valid_i = 1;
    vec_rsp_data_i  = word;
    tick();
    vec_rsp_valid_i = 0;
    check("R6 pc valid", 32'(pc_valid_o), 1);
    check("R6 pc value", pc_o, word << 1);
    check("R9 busy cleared", 32'(busy_o), 0);
    tick();
    check("R6 pc pulse", 32'(pc_valid_o), 0);
  endtask

  task automatic do_tret(logic [31:0] reg_v, logic [31:0] exp_status);
    tret_reg_i = reg_v;
    tret_i = 1;
    tick();
    tret_i = 0;
    check("R7 status restored", status_o, exp_status);
    check("R7 pc valid", 32'(pc_valid_o), 1);
    check("R7 pc value", pc_o, reg_v << 1);
  endtask

  task automatic t_reset();
    check("R8 cwp", 32'(cwp_o), HI);
    check("R8 status", status_o, mk(HI, 0, 63));
    check("R8 istatus", istatus_o, 0);
    check("R8 pulses", {29'b0, sp_we_o, link_we_o, pc_valid_o}, 0);
    check("R8 busy", 32'(busy_o), 0);
  endtask

  task automatic t_save_restore();
    fp_i = 32'h1000;
    save_imm_i = 8'd5;
    save_i = 1;
    tick();
    save_i = 0;
    check("R1 cwp", 32'(cwp_o), HI - 1);
    check("R1 sp we", 32'(sp_we_o), 1);
    check("R1 sp data", sp_data_o, 32'h0FEC);
    tick();
    check("R1 sp pulse", 32'(sp_we_o), 0);
    restore_i = 1;
    tick();
    restore_i = 0;
    check("R3 cwp up", 32'(cwp_o), HI);
  endtask

  task automatic t_underflow();
    pc_i = 32'h100;
    restore_i = 1;
    tick();
    restore_i = 0;
    check("R3 underflow cwp", 32'(cwp_o), HI - 1);
    check("R4 istatus", istatus_o, mk(HI, 0, 63));
    check("R4 status", status_o, mk(HI - 1, 0, 2));
    check("R5 link we", 32'(link_we_o), 1);
    check("R5 link data", link_data_o, 32'h81);
    check("R9 busy", 32'(busy_o), 1);
    serve("R3", VB + 8, 32'h1234, 0);
    do_tret(32'h40, mk(HI, 0, 63));
  endtask

  task automatic t_soft_trap_busy();
    pc_i = 32'h200;
    trap_num_i = 6'd5;
    trap_i = 1;
    tick();
    trap_i = 0;
    check("R4 trap cwp", 32'(cwp_o), HI - 1);
    check("R5 link data", link_data_o, 32'h101);
    save_i = 1;
    irq_i = 1;
    irq_pri_i = 0;
    tick();
    save_i = 0;
    irq_i = 0;
    check("R9 cwp frozen", 32'(cwp_o), HI - 1);
    check("R9 no sp write", 32'(sp_we_o), 0);
    check("R9 status frozen", status_o, mk(HI - 1, 0, 5));
    serve("R6", VB + 20, 32'h0000_8000, 2);
    do_tret(32'h10, mk(HI, 0, 63));
  endtask

  task automatic t_overflow();
    for (int i = HI; i > LO; i--) begin
      save_i = 1;
      tick();
    end
    save_i = 0;
    check("R1 reached low", 32'(cwp_o), LO);
    tick();
    save_i = 1;
    tick();
    save_i = 0;
    check("R2 overflow cwp", 32'(cwp_o), LO - 1);
    check("R2 no sp write", 32'(sp_we_o), 0);
    check("R2 trap number", status_o, mk(LO - 1, 0, 1));
    serve("R2", VB + 4, 32'h0000_0200, 1);
    do_tret(32'h20, mk(LO, 0, 63));
  endtask

  task automatic t_irq();
    status_wdata_i = mk(HI, 1, 10) | 32'hFFF0_00F0;
    status_we_i = 1;
    tick();
    status_we_i = 0;
    check("R10 status write", status_o, mk(HI, 1, 10) | (32'h0 << 4));
    check("R10 ie", 32'(ie_o), 1);
    irq_pri_i = 6'd12;
    irq_i = 1;
    tick();
    irq_i = 0;
    check("R11 low priority ignored", 32'(busy_o), 0);
    check("R11 cwp kept", 32'(cwp_o), HI);
    fp_i = 32'h2000;
    irq_pri_i = 6'd4;
    irq_i = 1;
    save_i = 1;
    tick();
    irq_i = 0;
    save_i = 0;
    check("R12 irq over save cwp", 32'(cwp_o), HI - 1);
    check("R12 no sp write", 32'(sp_we_o), 0);
    check("R11 istatus", istatus_o, mk(HI, 1, 10));
    check("R11 status", status_o, mk(HI - 1, 0, 4));
    serve("R11", VB + 16, 32'h44, 0);
    irq_pri_i = 6'd1;
    irq_i = 1;
    tick();
    irq_i = 0;
    check("R11 masked irq ignored", 32'(busy_o), 0);
    trap_num_i = 6'd7;
    trap_i = 1;
    restore_i = 1;
    tick();
    trap_i = 0;
    restore_i = 0;
    check("R12 trap over restore", 32'(cwp_o), HI - 2);
    check("R12 trap number", status_o, mk(HI - 2, 0, 7));
    serve("R12", VB + 28, 32'h50, 0);
  endtask

  initial begin
    tick();
    tick();
    rst_n = 1;
    tick();
    t_reset();
    t_save_restore();
    t_underflow();
    t_soft_trap_busy();
    t_overflow();
    t_irq();
    tick();
    finish_run();
  end
endmodule